// File: doc/BRIEF.md
# Mode-Selected Clock Ratio Divider

This block derives a family of related clocks from one fast master clock for a processor-board clock generator. Three select pins pick the operating mode: ordinary running with one of two ratio sets (fast or slow processor clock), running with the 48 MHz output released to high impedance, a test mode in which the master clock is an external test clock divided by fixed powers of two, and an all-high-impedance mode used for board test. The two reserved codes drop every output to high impedance as their safe state. An active-low spread request pin, together with two of the select pins, is reported as a status code naming the requested spread profile. No modulation is applied here.

All four divided clocks (processor, 66 MHz, PCI, interrupt controller) come from one counter chain that restarts as a unit, so their rising edges coincide. The reference and 48 MHz outputs pass through external sources in the running modes and are derived from the master clock in test mode. Each output has its own tri-state enable, and its data is held low while that enable is low. A change on the select pins is captured every master cycle but takes effect only when the chain restarts. This way no output is cut short.

Top module: `clk_mode_divider`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, every enable is low, every clock output is low and the spread status is 0 (none). After reset the active mode is the all-high-impedance code 000 until the first restart of the chain.
- R2: With the active select code {selHigh, selA, selB} = 000, all six enables are low and all six clock outputs stay low.
- R3: The reserved codes 001 and 101 behave exactly like code 000: all enables low and all outputs low.
- R4: Code 111 (fast ratios) enables all six outputs. The processor, 66 MHz, PCI and interrupt clocks have periods of 2, 4, 8 and 16 master cycles, each high for the first half of its period. The reference output follows refIn and the 48 MHz output follows usbIn.
- R5: Code 011 (slow ratios) enables all six outputs. The divided clocks have periods of 2, 3, 6 and 12 master cycles, each high for the first ceil(period/2) cycles. The chain restarts every 12 cycles instead of 16.
- R6: Codes 010 and 110 run like 011 and 111 respectively, except that the 48 MHz enable (outEn bit 5) is low and its output is low. Whenever outEn bit 5 is high, all other enables are high too.
- R7: Code 100 (test) enables all six outputs. The divided clocks run at master/2, /4, /8 and /16, the 48 MHz output at master/2, and the reference output equals the master clock.
- R8: Rising edges are aligned. Every rising edge of the PCI clock comes in the same cycle as a rising edge of the 66 MHz and processor clocks, and every rising edge of the interrupt clock comes with a rising edge of the PCI clock.
- R9: The select pins are registered each master cycle. The registered code becomes the active mode only in the cycle in which the chain counter is at its last phase (15, or 11 for the slow codes). Outputs and enables for the new mode appear one master cycle later, starting with all enabled divided clocks high.
- R10: The spread status is 0 when spreadN is high. When spreadN is low it is 1 (center spread) if the active code's {selA, selB} is 01, 2 (down spread) if it is 10 or 11, and 0 if it is 00. spreadN passes through two registers, while selA/selB come from the active mode. The value 3 never occurs.
- R11: The enable bit order of outEn is: bit 0 processor, 1 66 MHz, 2 PCI, 3 interrupt, 4 reference, 5 48 MHz. Enables change only at a restart, in the same cycle in which each newly enabled divided clock goes high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock (2x processor rate, or the test clock) |
| rstN | input | 1 | Asynchronous active-low reset |
| selHigh | input | 1 | Ratio select: 1 = fast set, 0 = slow set |
| selA | input | 1 | Mode select, upper bit |
| selB | input | 1 | Mode select, lower bit |
| spreadN | input | 1 | Active-low spread request |
| refIn | input | 1 | Reference clock source for running modes |
| usbIn | input | 1 | 48 MHz source for running modes |
| cpuClk | output | 1 | Processor clock |
| midClk | output | 1 | 66 MHz clock |
| pciClk | output | 1 | PCI clock |
| apicClk | output | 1 | Interrupt controller clock |
| refClk | output | 1 | Reference clock output |
| usbClk | output | 1 | 48 MHz clock output |
| outEn | output | 6 | Per-output tri-state enables (bit order in R11) |
| spreadCode | output | 2 | Requested spread profile status |

## Verification
The bench uses the default parameters: ratios 2/4/8/16 in the fast set and 2/3/6/12 in the slow set. The chain therefore restarts every 16 or 12 master cycles, and each mode switch settles within a few dozen cycles. This makes it practical to visit all eight select codes and both spread states, and to change the pins at many different phases of the chain, including several times within one restart window. Only the last captured code is expected to win.

// File: rtl/cmd_pkg.sv
package cmd_pkg;

  localparam int NUM_OUT = 6;
  localparam int NUM_DIV = 4;

  localparam int CH_CPU  = 0;
  localparam int CH_MID  = 1;
  localparam int CH_PCI  = 2;
  localparam int CH_APIC = 3;
  localparam int CH_REF  = 4;
  localparam int CH_USB  = 5;

  typedef enum logic [1:0] {
    SPR_NONE   = 2'd0,
    SPR_CENTER = 2'd1,
    SPR_DOWN   = 2'd2
  } spread_e;

  // strobes from the mode control to the divider datapath
  typedef struct packed {
    logic                lowRatio;
    logic                testMode;
    logic [NUM_OUT-1:0]  outEn;
    spread_e             spread;
  } ctrl_s;

endpackage

// File: rtl/cmd_ctrl.sv
module cmd_ctrl
  import cmd_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [2:0] selIn,
  input  logic       spreadNIn,
  input  logic       atWrap,
  output ctrl_s      ctrl
);

  logic [2:0] selQ;
  logic [2:0] activeCode;
  logic       spreadNQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selQ       <= 3'b000;
      activeCode <= 3'b000;
      spreadNQ   <= 1'b1;
    end else begin
      selQ     <= selIn;
      spreadNQ <= spreadNIn;
      if (atWrap) activeCode <= selQ;
    end
  end

  always_comb begin
    ctrl          = '0;
    ctrl.lowRatio = !activeCode[2] && activeCode[1];
    ctrl.testMode = (activeCode == 3'b100);
    if (activeCode[1]) begin
      ctrl.outEn         = '1;
      ctrl.outEn[CH_USB] = activeCode[0];
    end else if (ctrl.testMode) begin
      ctrl.outEn = '1;
    end
    if (spreadNQ) begin
      ctrl.spread = SPR_NONE;
    end else begin
      unique case (activeCode[1:0])
        2'b01:        ctrl.spread = SPR_CENTER;
        2'b10, 2'b11: ctrl.spread = SPR_DOWN;
        default:      ctrl.spread = SPR_NONE;
      endcase
    end
  end

endmodule

// File: rtl/cmd_div_chan.sv
module cmd_div_chan #(
  parameter int HI_DIV = 4,
  parameter int LO_DIV = 3
) (
  input  logic clk,
  input  logic rstN,
  input  logic restart,
  input  logic lowRatio,
  input  logic enable,
  output logic clkOut
);

  localparam int MAXD = (HI_DIV > LO_DIV) ? HI_DIV : LO_DIV;
  localparam int CW   = (MAXD > 2) ? $clog2(MAXD) : 1;
  localparam logic [CW:0] HI_LAST = (CW+1)'(HI_DIV - 1);
  localparam logic [CW:0] LO_LAST = (CW+1)'(LO_DIV - 1);
  localparam logic [CW:0] HI_HALF = (CW+1)'((HI_DIV + 1) / 2);
  localparam logic [CW:0] LO_HALF = (CW+1)'((LO_DIV + 1) / 2);

  logic [CW-1:0] cnt;
  logic [CW:0]   lastVal;
  logic [CW:0]   halfVal;

  assign lastVal = lowRatio ? LO_LAST : HI_LAST;
  assign halfVal = lowRatio ? LO_HALF : HI_HALF;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt    <= '0;
      clkOut <= 1'b0;
    end else begin
      if (restart || ({1'b0, cnt} == lastVal)) cnt <= '0;
      else                                     cnt <= cnt + 1'b1;
      clkOut <= enable && ({1'b0, cnt} < halfVal);
    end
  end

endmodule

// File: rtl/cmd_datapath.sv
module cmd_datapath
  import cmd_pkg::*;
#(
  parameter int CPU_DIV = 2,
  parameter int HI_MID  = 4,
  parameter int HI_PCI  = 8,
  parameter int HI_APIC = 16,
  parameter int LO_MID  = 3,
  parameter int LO_PCI  = 6,
  parameter int LO_APIC = 12
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrl_s              ctrl,
  input  logic               refIn,
  input  logic               usbIn,
  output logic               atWrap,
  output logic [NUM_DIV-1:0] divClk,
  output logic               refClk,
  output logic               usbClk,
  output logic [NUM_OUT-1:0] outEn,
  output spread_e            spreadCode
);

  localparam int HYPER = (HI_APIC > LO_APIC) ? HI_APIC : LO_APIC;
  localparam int PW    = $clog2(HYPER);
  localparam logic [PW-1:0] HI_LASTP = PW'(HI_APIC - 1);
  localparam logic [PW-1:0] LO_LASTP = PW'(LO_APIC - 1);
  localparam int HI_TAB [NUM_DIV] = '{CPU_DIV, HI_MID, HI_PCI, HI_APIC};
  localparam int LO_TAB [NUM_DIV] = '{CPU_DIV, LO_MID, LO_PCI, LO_APIC};

  logic [PW-1:0] phase;
  logic          testQ;
  logic          usbDiv;

  assign atWrap = (phase == (ctrl.lowRatio ? LO_LASTP : HI_LASTP));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase      <= '0;
      testQ      <= 1'b0;
      outEn      <= '0;
      spreadCode <= SPR_NONE;
    end else begin
      phase      <= atWrap ? '0 : phase + 1'b1;
      testQ      <= ctrl.testMode;
      outEn      <= ctrl.outEn;
      spreadCode <= ctrl.spread;
    end
  end

  for (genvar ch = 0; ch < NUM_DIV; ch++) begin : g_div
    cmd_div_chan #(
      .HI_DIV(HI_TAB[ch]),
      .LO_DIV(LO_TAB[ch])
    ) chan_i (
      .clk     (clk),
      .rstN    (rstN),
      .restart (atWrap),
      .lowRatio(ctrl.lowRatio),
      .enable  (ctrl.outEn[ch]),
      .clkOut  (divClk[ch])
    );
  end

  cmd_div_chan #(
    .HI_DIV(CPU_DIV),
    .LO_DIV(CPU_DIV)
  ) usbChan_i (
    .clk     (clk),
    .rstN    (rstN),
    .restart (atWrap),
    .lowRatio(ctrl.lowRatio),
    .enable  (ctrl.outEn[CH_USB] && ctrl.testMode),
    .clkOut  (usbDiv)
  );

  assign refClk = outEn[CH_REF] && (testQ ? clk : refIn);
  assign usbClk = outEn[CH_USB] && (testQ ? usbDiv : usbIn);

endmodule

// File: rtl/clk_mode_divider.sv
module clk_mode_divider
  import cmd_pkg::*;
#(
  parameter int CPU_DIV = 2,
  parameter int HI_MID  = 4,
  parameter int HI_PCI  = 8,
  parameter int HI_APIC = 16,
  parameter int LO_MID  = 3,
  parameter int LO_PCI  = 6,
  parameter int LO_APIC = 12
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       selHigh,
  input  logic       selA,
  input  logic       selB,
  input  logic       spreadN,
  input  logic       refIn,
  input  logic       usbIn,
  output logic       cpuClk,
  output logic       midClk,
  output logic       pciClk,
  output logic       apicClk,
  output logic       refClk,
  output logic       usbClk,
  output logic [5:0] outEn,
  output logic [1:0] spreadCode
);

  ctrl_s              ctrl;
  logic               atWrap;
  logic [NUM_DIV-1:0] divClk;
  spread_e            sprCode;

  cmd_ctrl ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .selIn    ({selHigh, selA, selB}),
    .spreadNIn(spreadN),
    .atWrap   (atWrap),
    .ctrl     (ctrl)
  );

  cmd_datapath #(
    .CPU_DIV(CPU_DIV), .HI_MID(HI_MID), .HI_PCI(HI_PCI), .HI_APIC(HI_APIC),
    .LO_MID(LO_MID), .LO_PCI(LO_PCI), .LO_APIC(LO_APIC)
  ) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .ctrl      (ctrl),
    .refIn     (refIn),
    .usbIn     (usbIn),
    .atWrap    (atWrap),
    .divClk    (divClk),
    .refClk    (refClk),
    .usbClk    (usbClk),
    .outEn     (outEn),
    .spreadCode(sprCode)
  );

  assign cpuClk     = divClk[CH_CPU];
  assign midClk     = divClk[CH_MID];
  assign pciClk     = divClk[CH_PCI];
  assign apicClk    = divClk[CH_APIC];
  assign spreadCode = sprCode;

endmodule

// File: rtl/clk_mode_divider_chk.sv
module clk_mode_divider_chk (
  input logic       clk,
  input logic       rstN,
  input logic       cpuClk,
  input logic       midClk,
  input logic       pciClk,
  input logic       apicClk,
  input logic       usbClk,
  input logic [5:0] outEn,
  input logic [1:0] spreadCode
);

  // R2: a disabled divided output holds low
  a_r2_disabled_low: assert property (@(posedge clk) disable iff (!rstN)
    (({apicClk, pciClk, midClk, cpuClk} & ~outEn[3:0]) == 4'b0000));

  // R6: 48 MHz output low while its enable is low
  a_r6_usb_low: assert property (@(posedge clk) disable iff (!rstN)
    !outEn[5] |-> !usbClk);

  // R6: 48 MHz enable implies every other enable
  a_r6_usb_implies_all: assert property (@(posedge clk) disable iff (!rstN)
    outEn[5] |-> (&outEn));

  // R4: processor clock toggles every cycle while enabled
  a_r4_cpu_toggles: assert property (@(posedge clk) disable iff (!rstN)
    outEn[0] |=> (!outEn[0] || (cpuClk != $past(cpuClk))));

  // R8: PCI rise aligned with 66 MHz and processor rises
  a_r8_pci_aligned: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pciClk) |-> ($rose(midClk) && $rose(cpuClk)));

  // R8: interrupt clock rise aligned with PCI rise
  a_r8_apic_aligned: assert property (@(posedge clk) disable iff (!rstN)
    $rose(apicClk) |-> $rose(pciClk));

  // R11: enables move only at a restart, where enabled clocks start high
  a_r11_enable_at_restart: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(outEn) |-> (cpuClk == outEn[0]));

  // R10: status never takes the unused value
  a_r10_code_valid: assert property (@(posedge clk) disable iff (!rstN)
    spreadCode != 2'b11);

endmodule

bind clk_mode_divider clk_mode_divider_chk chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .cpuClk    (cpuClk),
  .midClk    (midClk),
  .pciClk    (pciClk),
  .apicClk   (apicClk),
  .usbClk    (usbClk),
  .outEn     (outEn),
  .spreadCode(spreadCode)
);

// File: tb/clk_mode_divider_tb_top.sv
module clk_mode_divider_tb_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [2:0] modeBits = 3'b111;
  logic       spreadN = 1'b1;
  logic       refIn = 1'b0;
  logic       usbIn = 1'b0;
  logic       cpuClk, midClk, pciClk, apicClk, refClk, usbClk;
  logic [5:0] outEn;
  logic [1:0] spreadCode;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  clk_mode_divider dut_i (
    .clk(clk), .rstN(rstN),
    .selHigh(modeBits[2]), .selA(modeBits[1]), .selB(modeBits[0]),
    .spreadN(spreadN), .refIn(refIn), .usbIn(usbIn),
    .cpuClk(cpuClk), .midClk(midClk), .pciClk(pciClk), .apicClk(apicClk),
    .refClk(refClk), .usbClk(usbClk), .outEn(outEn), .spreadCode(spreadCode)
  );

  // external sources toggle between the two sampling points
  int srcCnt = 0;
  always @(posedge clk) begin
    #2;
    refIn = ~refIn;
    srcCnt++;
    if (srcCnt % 3 == 0) usbIn = ~usbIn;
  end

  // ---------------- reference model ----------------
  function automatic bit isLow(int m);
    return (m == 2) || (m == 3);
  endfunction

  function automatic int divOf(int m, int ch);
    case (ch)
      0: return 2;
      1: return isLow(m) ? 3 : 4;
      2: return isLow(m) ? 6 : 8;
      default: return isLow(m) ? 12 : 16;
    endcase
  endfunction

  function automatic bit [5:0] oeOf(int m);
    case (m)
      7, 3, 4: return 6'b111111;
      6, 2:    return 6'b011111;
      default: return 6'b000000;
    endcase
  endfunction

  function automatic bit [1:0] sprOf(int m, bit sq);
    if (sq) return 2'd0;
    case (m % 4)
      1:       return 2'd1;
      2, 3:    return 2'd2;
      default: return 2'd0;
    endcase
  endfunction

  int       phase, mode, selQm, outMode;
  bit       sprQm;
  bit [3:0] eDiv;
  bit       eUsbDiv, eTest, inReset;
  bit [5:0] eOe;
  bit [1:0] eSpr;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase = 0; mode = 0; selQm = 0; sprQm = 1; outMode = 0;
      eDiv = '0; eUsbDiv = 0; eTest = 0; eOe = '0; eSpr = '0;
      inReset = 1;
    end else begin
      inReset = 0;
      for (int ch = 0; ch < 4; ch++) begin
        int d;
        d = divOf(mode, ch);
        eDiv[ch] = oeOf(mode)[ch] && ((phase % d) < (d + 1) / 2);
      end
      eUsbDiv = (mode == 4) && (phase % 2 == 0);
      eOe     = oeOf(mode);
      eTest   = (mode == 4);
      eSpr    = sprOf(mode, sprQm);
      outMode = mode;
      if (phase == (isLow(mode) ? 12 : 16) - 1) begin
        phase = 0;
        mode  = selQm;
      end else begin
        phase++;
      end
      selQm = modeBits;
      sprQm = spreadN;
    end
  end

  function automatic string tagOf(int m, bit rst);
    if (rst) return "R1";
    case (m)
      0:       return "R2";
      1, 5:    return "R3";
      7:       return "R4";
      3:       return "R5";
      2, 6:    return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic chk(string tag, string what, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  logic prevCpu = 0, prevMid = 0, prevPci = 0, prevApic = 0;

  task automatic compareAll(bit edgeCheck);
    string t;
    t = tagOf(outMode, inReset);
    chk(t, "cpuClk",  8'(cpuClk),  8'(eDiv[0]));
    chk(t, "midClk",  8'(midClk),  8'(eDiv[1]));
    chk(t, "pciClk",  8'(pciClk),  8'(eDiv[2]));
    chk(t, "apicClk", 8'(apicClk), 8'(eDiv[3]));
    chk(eTest ? "R7" : t, "refClk", 8'(refClk),
        8'(eOe[4] && (eTest ? clk : refIn)));
    chk((outMode == 2 || outMode == 6) ? "R6" : t, "usbClk", 8'(usbClk),
        8'(eOe[5] && (eTest ? eUsbDiv : usbIn)));
    chk(inReset ? "R1" : "R9/R11", "outEn", 8'(outEn), 8'(eOe));
    chk(inReset ? "R1" : "R10", "spreadCode", 8'(spreadCode), 8'(eSpr));
    if (edgeCheck && !inReset) begin
      if (!prevPci && pciClk) begin
        chk("R8", "cpu rise with pci", 8'(!prevCpu && cpuClk), 8'd1);
        chk("R8", "mid rise with pci", 8'(!prevMid && midClk), 8'd1);
      end
      if (!prevApic && apicClk)
        chk("R8", "pci rise with apic", 8'(!prevPci && pciClk), 8'd1);
    end
    if (edgeCheck) begin
      prevCpu = cpuClk; prevMid = midClk; prevPci = pciClk; prevApic = apicClk;
    end
  endtask

  always @(posedge clk) begin
    #1;
    if (!done) compareAll(1'b0);
    #4;
    if (!done) compareAll(1'b1);
  end

  task automatic runCode(bit [2:0] code, bit spr, int n);
    @(negedge clk);
    modeBits = code;
    spreadN  = spr;
    repeat (n) @(negedge clk);
  endtask

  task automatic finishRun();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    // R1 is checked during reset and until the first restart
    runCode(3'b111, 1, 40);   // R4
    runCode(3'b111, 0, 20);   // R10 down spread
    runCode(3'b011, 0, 40);   // R5
    runCode(3'b010, 1, 40);   // R6 slow
    runCode(3'b110, 0, 40);   // R6 fast
    runCode(3'b100, 1, 50);   // R7
    runCode(3'b000, 0, 30);   // R2
    runCode(3'b001, 0, 30);   // R3, R10 center
    runCode(3'b101, 1, 30);   // R3
    runCode(3'b011, 1, 37);
    runCode(3'b111, 0, 29);
    // R9: select changes at assorted phases, some inside one window
    for (int i = 0; i < 40; i++) begin
      runCode(3'((i * 5 + 3) % 8), 1'((i / 3) % 2), 3 + (i * 7) % 19);
    end
    runCode(3'b100, 0, 40);
    runCode(3'b011, 0, 30);
    finishRun();
  end

  initial begin
    #(8 * 50000);
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    finishRun();
  end

endmodule